// File: doc/BRIEF.md
# Symbol Tracking Lock Detector

This block tells a receiver whether the soft symbols leaving its symbol-timing loop carry modulated data or only an unmodulated carrier. Each accepted soft symbol is first brought into a per-symbol value according to the line code in use. With Manchester coding the two half-symbol values are folded into one. With NRZ coding the value passes as it is. That value is squared into a power figure, and the power figures are summed over a window of programmable length. At the end of each window the magnitude of the sum is compared against a threshold.

The sense of the comparison depends on the carrier mode. A residual carrier with Manchester data declares data when the power is high. A suppressed carrier with NRZ data declares data when the power is low. The decision is held between windows and is gated by the carrier-lock input. A downstream decoder can therefore use the lock output directly to decide when symbols are worth processing.

Symbols arrive on a valid/ready stream. The block never applies back-pressure: ready is held high at all times, and a beat counts on every cycle in which valid is high. Control inputs are plain levels, and they should stay constant for the length of a window.

Top module: `sym_lock_det`

## Requirements
- R1: In NRZ mode (`manchester_i` = 0), every accepted symbol is one window value, equal to the symbol itself, and it contributes its square to the window sum.
- R2: In Manchester mode (`manchester_i` = 1), accepted beats are taken in pairs, first half and then second half, starting with the first beat after reset or after any NRZ beat. Each pair gives one window value, floor((first − second) / 2). The first beat of a pair adds nothing by itself.
- R3: A window holds 64 << `avg_len_i` values, so codes 0 to 7 select 64 up to 8192 values.
- R4: `avg_power_o` is the magnitude of the window sum, carried on 28 bits. It changes only when a window completes and holds its value otherwise. The next window starts from an empty sum.
- R5: In NRZ mode, a completed window declares data when `avg_power_o` ≤ `threshold_i`.
- R6: In Manchester mode, a completed window declares data when `avg_power_o` ≥ `threshold_i`.
- R7: `data_lock_o` is the stored decision ANDed with `carrier_lock_i` in the same cycle. It is never high while the carrier is unlocked, and the stored decision still updates at a window end while the carrier is unlocked.
- R8: `sym_ready_o` is always 1. Beats with `sym_valid_i` = 0 have no effect on the window, whatever `sym_data_i` carries.
- R9: After reset, `data_lock_o` = 0 and `avg_power_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Soft symbol beat valid |
| sym_ready_o | output | 1 | Always high; the block accepts every beat |
| sym_data_i | input | 8 | Signed soft symbol (two's complement) |
| manchester_i | input | 1 | 1 = residual carrier with Manchester data, 0 = suppressed carrier with NRZ data |
| carrier_lock_i | input | 1 | Carrier loop lock flag |
| avg_len_i | input | 3 | Window length code, 64 << code values |
| threshold_i | input | 28 | Unsigned power threshold |
| data_lock_o | output | 1 | Data-present flag, qualified by carrier lock |
| avg_power_o | output | 28 | Magnitude of the last completed window sum |

## Verification
The window dump and a change of carrier lock can land in the same cycle. In that case the stored decision must update while the output stays forced low. The bench provokes this by dropping `carrier_lock_i` on the very beat that closes a window, and it picks a threshold so that the new decision differs from the old one. It judges the outcome by checking that the lock stays low during the outage, and that once the carrier returns the lock shows the new decision while the power figure shows the new window sum.

// File: rtl/slk_pkg.sv
`timescale 1ns/1ps
package slk_pkg;
  // Line-code selector as seen on the mode pin
  typedef enum logic {
    FMT_NRZ = 1'b0,
    FMT_MAN = 1'b1
  } fmt_e;

  // Window length in values for a given code and base exponent
  function automatic int unsigned win_len(input int unsigned base_log,
                                          input int unsigned code);
    return 32'd1 << (base_log + code);
  endfunction
endpackage

// File: rtl/slk_reformat.sv
`timescale 1ns/1ps
module slk_reformat #(
  parameter int SYM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  slk_pkg::fmt_e           fmt,
  input  logic                    in_vld,
  input  logic signed [SYM_W-1:0] in_sym,
  output logic                    out_vld,
  output logic signed [SYM_W-1:0] out_val
);
  import slk_pkg::*;

  logic                    half_q;   // first half of a Manchester pair held
  logic signed [SYM_W-1:0] first_q;
  logic signed [SYM_W:0]   diff;

  assign diff = {first_q[SYM_W-1], first_q} - {in_sym[SYM_W-1], in_sym};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= '0;
      out_vld <= 1'b0;
      out_val <= '0;
    end else begin
      out_vld <= 1'b0;
      if (in_vld) begin
        if (fmt == FMT_NRZ) begin
          out_vld <= 1'b1;
          out_val <= in_sym;
          half_q  <= 1'b0;
        end else if (!half_q) begin
          first_q <= in_sym;
          half_q  <= 1'b1;
        end else begin
          out_vld <= 1'b1;
          out_val <= diff[SYM_W:1];  // floor of half the difference
          half_q  <= 1'b0;
        end
      end
    end
  end

  // R1: an NRZ beat reaches the next stage unchanged one cycle later
  p_nrz_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == FMT_NRZ) |=> (out_vld && out_val == $past(in_sym)));

  // R2: the first half of a Manchester pair yields no value
  p_first_half_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == FMT_MAN && !half_q) |=> !out_vld);

  // R8: without a valid beat nothing is produced
  p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
endmodule

// File: rtl/slk_square.sv
`timescale 1ns/1ps
module slk_square #(
  parameter int SYM_W = 8,
  parameter int PWR_W = 2*SYM_W - 1
) (
  input  logic signed [SYM_W-1:0] val,
  output logic        [PWR_W-1:0] pwr
);
  logic signed [2*SYM_W-1:0] prod;

  assign prod = val * val;
  assign pwr  = prod[PWR_W-1:0];

  // R1: a square is never negative and fits the power width
  always_comb begin
    a_square_fits_r1: assert (prod[2*SYM_W-1] == 1'b0);
  end
endmodule

// File: rtl/slk_integrate.sv
`timescale 1ns/1ps
module slk_integrate #(
  parameter int PWR_W    = 15,
  parameter int CODE_W   = 3,
  parameter int BASE_LOG = 6,
  parameter int CNT_W    = BASE_LOG + (1 << CODE_W) - 1,
  parameter int ACC_W    = PWR_W + CNT_W + 1,
  parameter int MAG_W    = ACC_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slk_pkg::fmt_e     fmt,
  input  logic [CODE_W-1:0] len_code,
  input  logic [MAG_W-1:0]  thresh,
  input  logic              pwr_vld,
  input  logic [PWR_W-1:0]  pwr,
  output logic [MAG_W-1:0]  avg_pwr,
  output logic              decision
);
  import slk_pkg::*;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum_nxt;
  logic signed [ACC_W-1:0] sum_abs;
  logic        [CNT_W-1:0] cnt_q;
  logic        [CNT_W:0]   len_full;
  logic        [CNT_W-1:0] len_m1;
  logic        [MAG_W-1:0] mag;
  logic                    last;
  logic                    verdict;

  assign len_full = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG + int'(len_code));
  assign len_m1   = CNT_W'(len_full - 1'b1);
  assign last     = (cnt_q >= len_m1);
  assign sum_nxt  = acc_q + $signed({{(ACC_W-PWR_W){1'b0}}, pwr});
  assign sum_abs  = sum_nxt[ACC_W-1] ? -sum_nxt : sum_nxt;
  assign mag      = sum_abs[MAG_W-1:0];
  assign verdict  = (fmt == FMT_MAN) ? (mag >= thresh) : (mag <= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      avg_pwr  <= '0;
      decision <= 1'b0;
    end else if (pwr_vld) begin
      if (last) begin
        acc_q    <= '0;
        cnt_q    <= '0;
        avg_pwr  <= mag;
        decision <= verdict;
      end else begin
        acc_q <= sum_nxt;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the reported power and decision hold between window ends
  p_hold_between_dumps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_vld && last) |=> ($stable(avg_pwr) && $stable(decision)));

  // R4: a completed window leaves an empty accumulator behind
  p_restart_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_vld && last) |=> (acc_q == 0 && cnt_q == 0));

  // R3: with a fixed code the count never passes the window end
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(len_code) |-> (cnt_q <= len_m1));

  if (ACC_W < PWR_W + 2) begin : g_bad_width
    initial $error("accumulator narrower than one power value");
  end
endmodule

// File: rtl/sym_lock_det.sv
`timescale 1ns/1ps
module sym_lock_det #(
  parameter int SYM_W    = 8,
  parameter int CODE_W   = 3,
  parameter int BASE_LOG = 6,
  localparam int PWR_W   = 2*SYM_W - 1,
  localparam int CNT_W   = BASE_LOG + (1 << CODE_W) - 1,
  localparam int ACC_W   = PWR_W + CNT_W + 1,
  localparam int MAG_W   = ACC_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_valid_i,
  output logic                    sym_ready_o,
  input  logic signed [SYM_W-1:0] sym_data_i,
  input  logic                    manchester_i,
  input  logic                    carrier_lock_i,
  input  logic [CODE_W-1:0]       avg_len_i,
  input  logic [MAG_W-1:0]        threshold_i,
  output logic                    data_lock_o,
  output logic [MAG_W-1:0]        avg_power_o
);
  import slk_pkg::*;

  fmt_e                    fmt;
  logic                    rf_vld;
  logic signed [SYM_W-1:0] rf_val;
  logic        [PWR_W-1:0] rf_pwr;
  logic                    dec;

  assign fmt         = manchester_i ? FMT_MAN : FMT_NRZ;
  assign sym_ready_o = 1'b1;

  slk_reformat #(.SYM_W(SYM_W)) u_reformat (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt     (fmt),
    .in_vld  (sym_valid_i),
    .in_sym  (sym_data_i),
    .out_vld (rf_vld),
    .out_val (rf_val)
  );

  slk_square #(.SYM_W(SYM_W), .PWR_W(PWR_W)) u_square (
    .val (rf_val),
    .pwr (rf_pwr)
  );

  slk_integrate #(
    .PWR_W(PWR_W), .CODE_W(CODE_W), .BASE_LOG(BASE_LOG),
    .CNT_W(CNT_W), .ACC_W(ACC_W), .MAG_W(MAG_W)
  ) u_integrate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .len_code (avg_len_i),
    .thresh   (threshold_i),
    .pwr_vld  (rf_vld),
    .pwr      (rf_pwr),
    .avg_pwr  (avg_power_o),
    .decision (dec)
  );

  assign data_lock_o = dec & carrier_lock_i;

  // R7: no data lock while the carrier is unlocked
  p_lock_needs_carrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_lock_o |-> carrier_lock_i);

  // R9: the first cycle out of reset shows no lock and no power
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!data_lock_o && avg_power_o == 0));
endmodule

// File: tb/sym_lock_det_tb.sv
`timescale 1ns/1ps
module sym_lock_det_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sym_valid_i = 1'b0;
  logic              sym_ready_o;
  logic signed [7:0] sym_data_i = '0;
  logic              manchester_i = 1'b0;
  logic              carrier_lock_i = 1'b1;
  logic [2:0]        avg_len_i = '0;
  logic [27:0]       threshold_i = '0;
  logic              data_lock_o;
  logic [27:0]       avg_power_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sym_lock_det u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .sym_valid_i    (sym_valid_i),
    .sym_ready_o    (sym_ready_o),
    .sym_data_i     (sym_data_i),
    .manchester_i   (manchester_i),
    .carrier_lock_i (carrier_lock_i),
    .avg_len_i      (avg_len_i),
    .threshold_i    (threshold_i),
    .data_lock_o    (data_lock_o),
    .avg_power_o    (avg_power_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one beat, driven on the falling edge
  task automatic send(input int v);
    sym_data_i  = 8'(v);
    sym_valid_i = 1'b1;
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic feed(input bit man, input int code, input int a, input int b, input int count);
    manchester_i = man;
    avg_len_i    = 3'(code);
    for (int i = 0; i < count; i++) begin
      send(a);
      if (man) send(b);
    end
  endtask

  task automatic t_reset();
    check(data_lock_o == 1'b0, "R9", data_lock_o, 0);
    check(avg_power_o == 0, "R9", avg_power_o, 0);
    check(sym_ready_o == 1'b1, "R8", sym_ready_o, 1);
  endtask

  task automatic t_nrz_equal();
    threshold_i = 28'd6400;
    feed(1'b0, 0, 10, 0, 64); settle();
    check(avg_power_o == 6400, "R1", avg_power_o, 6400);
    check(data_lock_o == 1'b1, "R5", data_lock_o, 1);
  endtask

  task automatic t_nrz_above();
    threshold_i = 28'd6399;
    feed(1'b0, 0, 10, 0, 64); settle();
    check(data_lock_o == 1'b0, "R5", data_lock_o, 0);
  endtask

  task automatic t_man_equal();
    threshold_i = 28'd25600;
    feed(1'b1, 0, 20, -20, 64); settle();
    check(avg_power_o == 25600, "R2", avg_power_o, 25600);
    check(data_lock_o == 1'b1, "R6", data_lock_o, 1);
  endtask

  task automatic t_man_below();
    threshold_i = 28'd25601;
    feed(1'b1, 0, 20, -20, 64); settle();
    check(data_lock_o == 1'b0, "R6", data_lock_o, 0);
  endtask

  task automatic t_man_floor();
    // (5 - 6) / 2 floors to -1, power 1 per pair
    threshold_i = 28'd0;
    feed(1'b1, 0, 5, 6, 64); settle();
    check(avg_power_o == 64, "R2", avg_power_o, 64);
    check(data_lock_o == 1'b1, "R6", data_lock_o, 1);
  endtask

  task automatic t_hold_len();
    threshold_i = 28'hFFFFFFF;
    feed(1'b0, 1, -3, 0, 64); settle();
    check(avg_power_o == 64, "R4", avg_power_o, 64);
    check(data_lock_o == 1'b1, "R4", data_lock_o, 1);
    feed(1'b0, 1, -3, 0, 64); settle();
    check(avg_power_o == 1152, "R3", avg_power_o, 1152);
  endtask

  task automatic t_gaps();
    threshold_i  = 28'd0;
    manchester_i = 1'b0;
    avg_len_i    = 3'd0;
    for (int i = 0; i < 64; i++) begin
      send(4);
      sym_data_i = 8'sd100;  // not valid: must be ignored
      @(negedge clk);
    end
    settle();
    check(avg_power_o == 1024, "R8", avg_power_o, 1024);
    check(data_lock_o == 1'b0, "R5", data_lock_o, 0);
  endtask

  task automatic t_carrier();
    carrier_lock_i = 1'b0;
    threshold_i    = 28'd6400;
    feed(1'b0, 0, 10, 0, 64); settle();
    check(avg_power_o == 6400, "R7", avg_power_o, 6400);
    check(data_lock_o == 1'b0, "R7", data_lock_o, 0);
    carrier_lock_i = 1'b1;
    #1;
    check(data_lock_o == 1'b1, "R7", data_lock_o, 1);
  endtask

  task automatic t_coincide();
    // dump and carrier loss on the same beat; new decision is "no data"
    threshold_i = 28'd0;
    feed(1'b0, 0, 1, 0, 63);
    carrier_lock_i = 1'b0;
    send(1);
    settle();
    check(data_lock_o == 1'b0, "R7", data_lock_o, 0);
    carrier_lock_i = 1'b1;
    @(negedge clk);
    check(data_lock_o == 1'b0, "R7", data_lock_o, 0);
    check(avg_power_o == 64, "R4", avg_power_o, 64);
  endtask

  task automatic t_max();
    threshold_i = 28'd0;
    feed(1'b0, 7, -128, 0, 8192); settle();
    check(avg_power_o == 28'd134217728, "R3", avg_power_o, 134217728);
    check(data_lock_o == 1'b0, "R5", data_lock_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_nrz_equal();
    t_nrz_above();
    t_man_equal();
    t_man_below();
    t_man_floor();
    t_hold_len();
    t_gaps();
    t_carrier();
    t_coincide();
    t_max();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule